// File: doc/BRIEF.md
# ADC Sample Accumulator and Decimator

This block sits downstream of a converter core and receives a stream of unsigned 12-bit conversion results. Each result comes with a valid strobe. It adds up a group of consecutive accepted samples, where the group size is a power of two, shifts the sum right by a power-of-two divide ratio, and emits one 16-bit result per completed group together with a one-cycle valid pulse. The output rate is therefore the input conversion rate divided by the group size.

Two modes choose the group size and the shift:

- **Custom averaging** takes the group size and the divide ratio directly from the inputs.
- **Oversampling** selects one of four presets. Each preset fixes the group size to a power of four and the shift to half its base-two logarithm, so the effective resolution is 13, 14, 15 or 16 bits.

The configuration is captured when a group's first sample arrives. A flush input discards a partial group without producing a result.

Top module: `adc_accum_decim`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` is 0 until the first group completes.
- R2: With `mode`=0 (custom averaging), a group holds 2^`avg_log2` accepted samples for `avg_log2` 0..10. Values 11..15 are treated as 10, giving 1024 samples.
- R3: In custom averaging the result is the group sum shifted right by `div_log2` (0..7), keeping the least significant 16 bits of the shifted value.
- R4: With `mode`=1 (oversampling), `os_sel`=k (0..3) gives a group of 4^(k+1) samples (4, 16, 64, 256) and a right shift of k+1 bits.
- R5: `out_valid` is high for exactly the one cycle after the clock edge that accepts a group's last sample, and `out_data` changes only in that cycle.
- R6: The internal sum is 22 bits wide. A 1024-sample group of 4095 values keeps its full sum of 4193280; with a shift of 7 the result is 32760.
- R7: `flush` clears the partial sum and the sample count and produces no result. A sample presented in the same cycle as `flush` is dropped.
- R8: `mode`, `os_sel`, `avg_log2` and `div_log2` are captured on the clock edge that accepts a group's first sample. Changes made during a group take effect from the next group.
- R9: Cycles with `in_valid` low add nothing to the sum and do not advance the group count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Unsigned conversion result |
| flush | input | 1 | Discard the partial group |
| mode | input | 1 | 0 = custom averaging, 1 = oversampling preset |
| os_sel | input | 2 | Oversampling preset (13 to 16 bits) |
| avg_log2 | input | 4 | log2 of the group size in custom mode |
| div_log2 | input | 3 | log2 of the divide ratio in custom mode |
| out_valid | output | 1 | One-cycle pulse per completed group |
| out_data | output | 16 | Decimated result, held between pulses |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a 1024-sample maximum group and a 16-bit output. At these values a full 1024-sample group of full-scale inputs is reachable, so both the top bit of the 22-bit sum and the 16-bit truncation of an unshifted large sum are observed at the output. All four oversampling presets are reachable at these sizes, including the 256-sample one. Gapped strobes, flushes in the middle of a group and configuration changes in the middle of a group are also reachable.

// File: rtl/adc_accum_decim.sv
module adc_accum_decim #(
  parameter int IN_W         = 12,
  parameter int OUT_W        = 16,
  parameter int CNT_LOG2_MAX = 10,
  parameter int AVG_W        = 4,
  parameter int DIV_W        = 3,
  parameter int OS_SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  input  logic             flush,
  input  logic             mode,
  input  logic [OS_SEL_W-1:0] os_sel,
  input  logic [AVG_W-1:0] avg_log2,
  input  logic [DIV_W-1:0] div_log2,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int ACC_W = IN_W + CNT_LOG2_MAX;
  localparam int IDX_W = CNT_LOG2_MAX;
  localparam int LG_W  = $clog2(CNT_LOG2_MAX + 1);

  logic [ACC_W-1:0] acc;
  logic [IDX_W-1:0] idx;
  logic [LG_W-1:0]  lg_q;
  logic [DIV_W-1:0] sh_q;

  logic [LG_W-1:0]  req_lg, cur_lg;
  logic [DIV_W-1:0] req_sh, cur_sh;
  logic [IDX_W-1:0] last_idx;
  logic [ACC_W-1:0] sum, shifted;
  logic             first;

  always_comb begin
    if (mode) begin
      req_lg = LG_W'((32'(os_sel) + 1) * 2);
      req_sh = DIV_W'(32'(os_sel) + 1);
    end else begin
      req_lg = (32'(avg_log2) > CNT_LOG2_MAX) ? LG_W'(CNT_LOG2_MAX) : LG_W'(avg_log2);
      req_sh = div_log2;
    end
  end

  assign first    = (idx == '0);
  assign cur_lg   = first ? req_lg : lg_q;
  assign cur_sh   = first ? req_sh : sh_q;
  assign last_idx = IDX_W'((32'd1 << cur_lg) - 32'd1);
  assign sum      = acc + ACC_W'(in_sample);
  assign shifted  = sum >> cur_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      idx       <= '0;
      lg_q      <= '0;
      sh_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (flush) begin
        acc <= '0;
        idx <= '0;
      end else if (in_valid) begin
        if (first) begin
          lg_q <= req_lg;
          sh_q <= req_sh;
        end
        if (idx == last_idx) begin
          out_valid <= 1'b1;
          out_data  <= shifted[OUT_W-1:0];
          acc       <= '0;
          idx       <= '0;
        end else begin
          acc <= sum;
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

module adc_accum_decim_chk #(
  parameter int OUT_W        = 16,
  parameter int CNT_LOG2_MAX = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             flush,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  logic [CNT_LOG2_MAX+1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) seen <= '0;
    else if (out_valid) seen <= in_valid ? 1 : 0;
    else if (in_valid) seen <= seen + 1'b1;
  end

  a_r5_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && !$past(flush)));

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r7_flush_silent: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  a_r2_group_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= (1 << CNT_LOG2_MAX));
endmodule

bind adc_accum_decim adc_accum_decim_chk #(.OUT_W(OUT_W), .CNT_LOG2_MAX(CNT_LOG2_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flush(flush),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/adc_accum_decim_test.sv
module adc_accum_decim_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [11:0] in_sample = 0;
  logic        flush = 0;
  logic        mode = 0;
  logic [1:0]  os_sel = 0;
  logic [3:0]  avg_log2 = 0;
  logic [2:0]  div_log2 = 0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int failures = 0;

  adc_accum_decim uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .flush(flush), .mode(mode), .os_sel(os_sel), .avg_log2(avg_log2),
    .div_log2(div_log2), .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit m, input int sel, input int avg, input int dv);
    mode = m; os_sel = 2'(sel); avg_log2 = 4'(avg); div_log2 = 3'(dv);
  endtask

  task automatic run_group(input string req, input int n, input int base, input int step,
                           input int sh, input bit gaps);
    longint s = 0;
    longint exp;
    for (int i = 0; i < n; i++) begin
      int v = (base + i * step) % 4096;
      @(negedge clk);
      if (i > 0 && out_valid) chk(0, req, 1, 0);
      if (gaps && (i % 3 == 1)) begin
        in_valid = 0;
        in_sample = 12'hABC;
        @(negedge clk);
        if (out_valid) chk(0, {req, " R9 gap"}, 1, 0);
      end
      in_valid = 1;
      in_sample = 12'(v);
      s += v;
    end
    @(negedge clk);
    in_valid = 0;
    exp = (s >> sh) & 64'hFFFF;
    chk(out_valid == 1, {req, " R5 valid"}, out_valid, 1);
    chk(out_data == 16'(exp), {req, " data"}, out_data, exp);
    @(negedge clk);
    chk(out_valid == 0, {req, " R5 pulse width"}, out_valid, 0);
    chk(out_data == 16'(exp), {req, " R5 hold"}, out_data, exp);
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(out_data == 0, "R1 data", out_data, 0);
  endtask

  task automatic t_custom();
    set_cfg(0, 0, 0, 0);
    run_group("R2 single", 1, 1234, 0, 0, 0);
    set_cfg(0, 0, 3, 0);
    run_group("R2 eight", 8, 4095, 0, 0, 0);
    set_cfg(0, 0, 4, 3);
    run_group("R3 ramp div8", 16, 100, 250, 3, 0);
    set_cfg(0, 0, 10, 7);
    run_group("R6 full scale", 1024, 4095, 0, 7, 0);
    set_cfg(0, 0, 10, 0);
    run_group("R3 truncate", 1024, 4095, 0, 0, 0);
    set_cfg(0, 0, 15, 0);
    run_group("R2 clamp", 1024, 1, 0, 0, 0);
  endtask

  task automatic t_oversample();
    for (int k = 0; k < 4; k++) begin
      set_cfg(1, k, 0, 0);
      run_group($sformatf("R4 preset%0d", k), 1 << (2 * (k + 1)), 37 * k + 5, 311, k + 1, 0);
    end
  endtask

  task automatic t_gaps();
    set_cfg(0, 0, 2, 1);
    run_group("R9 gaps", 4, 4000, 17, 1, 1);
  endtask

  task automatic t_cfg_change();
    set_cfg(0, 0, 2, 0);
    @(negedge clk);
    in_valid = 1; in_sample = 12'd10;
    @(negedge clk);
    set_cfg(0, 0, 0, 5);
    in_sample = 12'd20;
    @(negedge clk);
    chk(out_valid == 0, "R8 no early result", out_valid, 0);
    in_sample = 12'd30;
    @(negedge clk);
    chk(out_valid == 0, "R8 no early result", out_valid, 0);
    in_sample = 12'd40;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1 && out_data == 16'd100, "R8 old config", out_data, 100);
    run_group("R8 new config", 1, 64, 0, 5, 0);
  endtask

  task automatic t_flush();
    set_cfg(0, 0, 2, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1; in_sample = 12'd900;
    end
    @(negedge clk);
    flush = 1; in_sample = 12'd777;
    @(negedge clk);
    flush = 0; in_valid = 0;
    chk(out_valid == 0, "R7 flush no output", out_valid, 0);
    run_group("R7 after flush", 4, 5, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_custom();
    t_oversample();
    t_gaps();
    t_cfg_change();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule